// File: doc/BRIEF.md
# Ping-Pong Accumulator With ReLU Readout

This block is the result store that sits between a multiply-accumulate array and the activation stage. Its storage is split into two halves. The producer (the array) owns one half. Into that half it writes partial-sum vectors, each either replacing the stored entry or added onto it. At the same time an internal sequencer drains the other half in address order. The sequencer passes each 32-bit lane through ReLU, clamps it to an 8-bit unsigned value and presents the narrowed vector on a valid/ready output.

When the producer has finished its half it raises `prod_done` together with the number of entries to drain. The two halves change owner only when the producer has finished and the consumer has emptied its half. Whichever side finishes first waits for the other. While a finished producer waits, `wr_open` is low. Each change of owner is marked by a one-cycle `swap` pulse.

The exchange is run by a state machine with three states:
- `SW_FILL_EMPTY`: the producer is filling and the consumer half is empty.
- `SW_FILL_DRAIN`: the producer is filling and the consumer is draining.
- `SW_HOLD`: the producer is done and waits for the drain to finish.

Its transitions are:
- FILL_EMPTY to FILL_DRAIN, on done (swap).
- FILL_DRAIN to FILL_DRAIN, on done in the same cycle as the last beat is accepted (swap).
- FILL_DRAIN to HOLD, on done while the drain is still running.
- FILL_DRAIN to FILL_EMPTY, when the drain ends with no done.
- HOLD to FILL_DRAIN, when the drain ends (swap).

The default parameters give a small instance. The full configuration is 32 lanes with `ADDR_W` = 11, which gives 2K entries per half and 4K in total.

Top module: `pingpong_relu_acc`

## Requirements
- R1: After reset, `prod_bank` is 0, `wr_open` is 1, `out_valid` is 0 and `swap` is 0.
- R2: A write with `wr_add` = 0 stores `wr_data` at `wr_addr` of the producer half. Lane i of `wr_data` occupies bits [i*ACC_W +: ACC_W].
- R3: A write with `wr_add` = 1 adds each lane of `wr_data` to the stored lane, modulo 2^ACC_W.
- R4: Writes to the same address in consecutive cycles accumulate exactly as if they had been spaced apart.
- R5: A `prod_done` accepted while the consumer half is empty raises `swap` in that same cycle, and `prod_bank` flips at the next clock edge.
- R6: After a swap, the released half is read out from address 0 up to `done_len`-1, one output beat per entry, in address order, with no beat lost or repeated.
- R7: Any output lane whose source is negative in two's complement is 0. Lane i of `out_data` occupies bits [i*OUT_W +: OUT_W].
- R8: A non-negative source lane above 255 is output as 255; a source lane from 0 to 255 passes through unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged.
- R10: A `prod_done` accepted while the consumer is still draining drops `wr_open` to 0 from the next cycle. The swap is then deferred to the cycle in which the last beat of the drain is accepted.
- R11: While `wr_open` is 0, writes and `prod_done` are ignored.
- R12: A swap with `done_len` = 0 produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_add | input | 1 | 1: add onto the entry, 0: overwrite it |
| wr_addr | input | ADDR_W | Entry index within the producer half |
| wr_data | input | LANES*ACC_W | Partial-sum vector |
| prod_done | input | 1 | Producer has finished its half |
| done_len | input | ADDR_W+1 | Entries to drain from the finished half |
| wr_open | output | 1 | Producer may write and signal done |
| swap | output | 1 | Halves change owner at the next edge |
| prod_bank | output | 1 | Half currently owned by the producer |
| out_valid | output | 1 | Output beat available |
| out_ready | input | 1 | Consumer of the output accepts the beat |
| out_data | output | LANES*OUT_W | ReLU-clamped vector |

## Verification
The assertions assume that `done_len` never exceeds the depth of one half and that `rst_n` is released away from a clock edge. They make no assumption about `out_ready`, which may stall at any time. The stimulus keeps `done_len` within the half and overwrites every entry before it first adds onto it. The stimulus drives `prod_done` in three situations: on the very cycle of a final write, while the output is stalled, and again while the block waits. This covers the write-to-read hazard at the swap, the deferred swap and the ignored inputs, all inside those assumptions.

// File: rtl/pingpong_acc_pkg.sv
package pingpong_acc_pkg;
    typedef enum logic [1:0] {
        SW_FILL_EMPTY,
        SW_FILL_DRAIN,
        SW_HOLD
    } swap_state_e;
endpackage

// File: rtl/acc_relu_narrow.sv
module acc_relu_narrow #(
    parameter int IN_W  = 32,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  acc,
    output logic [OUT_W-1:0] act
);
    localparam logic [IN_W-1:0] CEIL = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    always_comb begin
        if (acc[IN_W-1])      act = '0;
        else if (acc > CEIL)  act = '1;
        else                  act = acc[OUT_W-1:0];
    end
endmodule

// File: rtl/acc_rmw_bank.sv
module acc_rmw_bank #(
    parameter int LANES  = 4,
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_bank,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic                   wr_add,
    input  logic [LANES*ACC_W-1:0] wr_data,
    input  logic                   rd_en,
    input  logic                   rd_bank,
    input  logic [ADDR_W-1:0]      rd_addr,
    output logic [LANES*ACC_W-1:0] rd_data,
    output logic                   pend_valid,
    output logic                   pend_bank
);
    localparam int VEC_W   = LANES * ACC_W;
    localparam int FULL_W  = ADDR_W + 1;
    localparam int ENTRIES = 2 ** FULL_W;

    logic [VEC_W-1:0]  store [ENTRIES];
    logic              s1_valid, s1_add, byp_hit;
    logic [FULL_W-1:0] s1_addr;
    logic [VEC_W-1:0]  s1_data, s1_old, byp_data, base, result;
    logic [FULL_W-1:0] wr_full;

    assign wr_full = {wr_bank, wr_addr};

    always_comb begin
        base = byp_hit ? byp_data : s1_old;
        for (int l = 0; l < LANES; l++) begin
            result[l*ACC_W +: ACC_W] = s1_add ? base[l*ACC_W +: ACC_W] + s1_data[l*ACC_W +: ACC_W]
                                              : s1_data[l*ACC_W +: ACC_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_add   <= 1'b0;
            s1_addr  <= '0;
            s1_data  <= '0;
            byp_hit  <= 1'b0;
            byp_data <= '0;
        end else begin
            s1_valid <= wr_en;
            if (wr_en) begin
                s1_add  <= wr_add;
                s1_addr <= wr_full;
                s1_data <= wr_data;
            end
            byp_hit  <= wr_en && s1_valid && (s1_addr == wr_full);
            byp_data <= result;
        end
    end

    always_ff @(posedge clk) begin
        if (s1_valid) store[s1_addr] <= result;
        s1_old <= store[wr_full];
        if (rd_en) rd_data <= store[{rd_bank, rd_addr}];
    end

    assign pend_valid = s1_valid;
    assign pend_bank  = s1_addr[FULL_W-1];
endmodule

// File: rtl/acc_swap_ctrl.sv
module acc_swap_ctrl
    import pingpong_acc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_req,
    input  logic [ADDR_W:0]   done_len,
    input  logic              out_valid,
    input  logic              out_ready,
    input  logic              hazard,
    output logic              prod_bank,
    output logic              wr_open,
    output logic              swap,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr
);
    swap_state_e state, nxt;
    logic [ADDR_W:0] len_q, ptr, hold_len, swap_len;
    logic draining, slot_free, at_end, drain_done, swap_go;

    always_comb begin
        draining   = (state != SW_FILL_EMPTY);
        slot_free  = !out_valid || out_ready;
        at_end     = (ptr == len_q);
        drain_done = draining && at_end && slot_free;
    end

    always_comb begin
        nxt      = state;
        swap_go  = 1'b0;
        swap_len = done_len;
        unique case (state)
            SW_FILL_EMPTY: begin
                if (done_req) begin
                    swap_go = 1'b1;
                    nxt     = SW_FILL_DRAIN;
                end
            end
            SW_FILL_DRAIN: begin
                if (done_req && drain_done) swap_go = 1'b1;
                else if (done_req)          nxt = SW_HOLD;
                else if (drain_done)        nxt = SW_FILL_EMPTY;
            end
            SW_HOLD: begin
                if (drain_done) begin
                    swap_go  = 1'b1;
                    swap_len = hold_len;
                    nxt      = SW_FILL_DRAIN;
                end
            end
            default: nxt = SW_FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SW_FILL_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_bank <= 1'b0;
            len_q     <= '0;
            ptr       <= '0;
            hold_len  <= '0;
        end else begin
            if (swap_go) begin
                prod_bank <= !prod_bank;
                len_q     <= swap_len;
                ptr       <= '0;
            end else if (rd_en) begin
                ptr <= ptr + 1'b1;
            end
            if (state == SW_FILL_DRAIN && done_req && !drain_done) hold_len <= done_len;
        end
    end

    always_comb begin
        wr_open = (state != SW_HOLD);
        swap    = swap_go;
        rd_en   = draining && !at_end && slot_free && !hazard;
        rd_addr = ptr[ADDR_W-1:0];
    end
endmodule

// File: rtl/pingpong_relu_acc.sv
module pingpong_relu_acc #(
    parameter int LANES  = 4,
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 8,
    parameter int ADDR_W = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic                   wr_add,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [LANES*ACC_W-1:0] wr_data,
    input  logic                   prod_done,
    input  logic [ADDR_W:0]        done_len,
    output logic                   wr_open,
    output logic                   swap,
    output logic                   prod_bank,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LANES*OUT_W-1:0] out_data
);
    localparam int VEC_W = LANES * ACC_W;

    logic              wr_en, rd_en, pend_valid, pend_bank, hazard;
    logic [ADDR_W-1:0] rd_addr;
    logic [VEC_W-1:0]  rd_data;

    assign wr_en  = wr_valid && wr_open;
    assign hazard = pend_valid && (pend_bank == !prod_bank);

    acc_swap_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_req  (prod_done),
        .done_len  (done_len),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .hazard    (hazard),
        .prod_bank (prod_bank),
        .wr_open   (wr_open),
        .swap      (swap),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr)
    );

    acc_rmw_bank #(.LANES(LANES), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_bank    (prod_bank),
        .wr_addr    (wr_addr),
        .wr_add     (wr_add),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_bank    (!prod_bank),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pend_valid (pend_valid),
        .pend_bank  (pend_bank)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (rd_en)     out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        acc_relu_narrow #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_act (
            .acc (rd_data[g*ACC_W +: ACC_W]),
            .act (out_data[g*OUT_W +: OUT_W])
        );
    end
endmodule

// File: rtl/pingpong_relu_acc_chk.sv
module pingpong_relu_acc_chk #(
    parameter int VEC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_open,
    input logic             swap,
    input logic             prod_bank,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_data
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !prod_bank && wr_open);

    assert_swap_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> prod_bank != $past(prod_bank));

    assert_bank_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(prod_bank));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_deferred_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_open && swap |-> !out_valid || out_ready);
endmodule

bind pingpong_relu_acc pingpong_relu_acc_chk #(.VEC_W(LANES*OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_open   (wr_open),
    .swap      (swap),
    .prod_bank (prod_bank),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/pingpong_relu_acc_test.sv
module pingpong_relu_acc_test;
    localparam int LANES = 4, ACC_W = 32, OUT_W = 8, ADDR_W = 5;

    // row: [133] add flag, [132:128] address, [127:0] lanes 3..0
    localparam logic [133:0] TBL [9] = '{
        {1'b0, 5'd0, 32'd255,  32'd300,   -32'sd5,   32'd10},
        {1'b1, 5'd0, 32'd1,    32'd0,     32'd3,     32'd5},
        {1'b0, 5'd1, 32'd3,    32'd2,     32'd1,     32'd0},
        {1'b0, 5'd2, 32'd1000, 32'd254,   32'd128,   -32'sd1},
        {1'b1, 5'd1, 32'd100,  32'd100,   32'd100,   32'd100},
        {1'b1, 5'd2, 32'd0,    32'd1,     -32'sd200, 32'd2},
        {1'b0, 5'd3, 32'd7,    32'd7,     -32'sd100, -32'sd100},
        {1'b1, 5'd3, 32'd250,  -32'sd7,   32'd50,    32'd200},
        {1'b1, 5'd3, 32'd1,    32'd1,     32'd1,     32'd1}
    };
    localparam logic [31:0] EXP0 [4] = '{32'hFFFF000F, 32'h67666564, 32'hFFFF0001, 32'hFF010065};
    localparam logic [31:0] EXP1 [3] = '{32'h04030201, 32'h00FF0900, 32'h4D00004D};
    localparam logic [127:0] B1W [3] = '{
        {32'd4,  32'd3, 32'd2,   32'd1},
        {32'd0,  32'd500, 32'd9, -32'sd9},
        {32'd77, 32'd0, 32'd0,   32'd77}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 1'b0, wr_add = 1'b0, prod_done = 1'b0, out_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [LANES*ACC_W-1:0] wr_data = '0;
    logic [ADDR_W:0] done_len = '0;
    logic wr_open, swap, prod_bank, out_valid;
    logic [LANES*OUT_W-1:0] out_data;

    int checks = 0, errors = 0, got_n = 0, swap_n = 0, swap_beats = -1;
    logic [31:0] got [16];
    bit finished = 1'b0;
    bit seen_valid;

    always #5 clk = ~clk;

    pingpong_relu_acc #(.LANES(LANES), .ACC_W(ACC_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_add(wr_add), .wr_addr(wr_addr),
        .wr_data(wr_data), .prod_done(prod_done), .done_len(done_len), .wr_open(wr_open),
        .swap(swap), .prod_bank(prod_bank), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (got_n < 16) got[got_n] = out_data;
                got_n++;
            end
            if (swap) begin
                swap_n++;
                swap_beats = got_n;
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 prod_bank", prod_bank, 0);
        chk("R1 wr_open", wr_open, 1);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 swap", swap, 0);

        // R2 R3 R4: table of overwrite/accumulate writes, done on the last one
        for (int i = 0; i < 9; i++) begin
            tick();
            wr_valid = 1'b1;
            wr_add   = TBL[i][133];
            wr_addr  = TBL[i][132:128];
            wr_data  = TBL[i][127:0];
            if (i == 8) begin
                prod_done = 1'b1;
                done_len  = 6'd4;
                @(negedge clk);
                chk("R5 swap on done", swap, 1);
            end
        end
        tick();
        wr_valid = 1'b0;
        prod_done = 1'b0;
        @(negedge clk);
        chk("R5 prod_bank flipped", prod_bank, 1);

        repeat (3) @(negedge clk);
        chk("R9 stalled valid", out_valid, 1);
        chk("R7 R8 first beat", out_data, EXP0[0]);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 beat held", {out_valid, out_data}, {1'b1, EXP0[0]});
        end

        // fill the other half while the output is stalled
        for (int i = 0; i < 3; i++) begin
            tick();
            wr_valid = 1'b1;
            wr_add   = 1'b0;
            wr_addr  = 5'(i);
            wr_data  = B1W[i];
        end
        tick();
        wr_valid  = 1'b0;
        prod_done = 1'b1;
        done_len  = 6'd3;
        tick();
        prod_done = 1'b0;
        @(negedge clk);
        chk("R10 wr_open low", wr_open, 0);
        chk("R10 swap deferred", swap_n, 1);

        // R11: write and done while closed must be dropped
        tick();
        wr_valid  = 1'b1;
        wr_addr   = 5'd0;
        wr_data   = {4{32'd50}};
        prod_done = 1'b1;
        done_len  = 6'd1;
        tick();
        wr_valid  = 1'b0;
        prod_done = 1'b0;
        @(negedge clk);
        chk("R11 still closed", wr_open, 0);

        tick();
        out_ready = 1'b1;
        for (int w = 0; w < 60 && got_n < 7; w++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk("R6 beat count", got_n, 7);
        for (int i = 0; i < 4; i++) chk("R6 R7 R8 R4 R3 half0 order", got[i], EXP0[i]);
        for (int i = 0; i < 3; i++) chk("R2 R11 half1 order", got[4+i], EXP1[i]);
        chk("R10 swap at last beat", swap_beats, 4);
        chk("R10 swap count", swap_n, 2);
        chk("R5 prod_bank back", prod_bank, 0);
        chk("R10 wr_open reopened", wr_open, 1);

        // R12: empty drain
        tick();
        prod_done = 1'b1;
        done_len  = 6'd0;
        tick();
        prod_done = 1'b0;
        seen_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (out_valid) seen_valid = 1'b1;
        end
        chk("R12 no beat", seen_valid, 0);
        chk("R12 beat count", got_n, 7);
        chk("R12 swap taken", swap_n, 3);
        chk("R12 prod_bank", prod_bank, 1);
        chk("R12 wr_open", wr_open, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule